// File: doc/BRIEF.md
# Four-Channel Compare PWM Unit

This block turns a shared 16-bit timer value into four pulse-width modulated outputs. Each of the four channels (A, B, C, D at bit indices 0 to 3) keeps its own compare value and checks it against the timer on every clock. A match sets a sticky per-channel flag and moves that channel's output between its active and inactive levels. The timer itself sits outside the block. It provides its count, a direction bit and a one-cycle pulse at the moment it reloads.

Two PWM shapes are available. The edge-aligned shape suits an up-counting timer: the output goes active on reload and inactive on match. The centre-aligned shape suits an up/down timer: a match while counting up makes the output active, and a match while counting down makes it inactive. Software writes compare values into a holding register. The value takes effect only at the next timer reload, so a period is never cut short by a mid-period update. Each output level can be inverted per channel. The flags, gated by per-channel interrupt enables, form one shared interrupt request.

All pins are plain control or status signals. No data stream crosses the block boundary, so no valid/ready handshake and no back-pressure apply.

Top module: `cpwm_top`

## Requirements
- R1: The four channels act independently. Each one compares `tmr_val` against its own active compare value, and a match on one channel changes no other channel's flag or output.
- R2: While `ch_en[i]` is 0, channel i never sets its flag and its internal level is held inactive. `pwm_out[i]` then equals `ch_pol[i]`, which is the inactive level.
- R3: If `ch_en[i]` is 1 and `tmr_val` equals the active compare value at a rising clock edge, `cmp_flag[i]` reads 1 after that edge. The flag stays set until `flag_clr[i]` is sampled high. A match in the same cycle as a clear wins, and the flag stays set.
- R4: `irq` is 1 exactly when some channel i has both `cmp_flag[i]` and `ch_ie[i]` set.
- R5: With `ch_pol[i]`=0 the active level of `pwm_out[i]` is 1. With `ch_pol[i]`=1 the output is inverted, so the active level is 0. A change of `ch_pol` shows on the output without waiting for a clock edge.
- R6: With `sym_mode`=0, an enabled channel goes active at a clock edge where `tmr_reload` is 1 and goes inactive at an edge where it matches. If both happen at the same edge, the match wins and the channel goes inactive.
- R7: With `sym_mode`=1, a match while `tmr_dir_down`=0 makes the channel active, and a match while `tmr_dir_down`=1 makes it inactive. In this mode `tmr_reload` does not change the output level.
- R8: A pulse on `cmp_wr[i]` stores `cmp_wdata` in channel i's holding register only. The active compare value takes the held value at the next edge with `tmr_reload`=1. The match at that same edge still uses the old active value.
- R9: After reset, all flags are 0, all held and active compare values are 0, every channel level is inactive (`pwm_out` = `ch_pol`), and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_val | input | 16 | Current timer count |
| tmr_dir_down | input | 1 | 1 while the timer counts down |
| tmr_reload | input | 1 | One-cycle pulse when the timer reloads |
| sym_mode | input | 1 | 0 edge-aligned PWM, 1 centre-aligned PWM |
| ch_en | input | 4 | Per-channel enable |
| ch_pol | input | 4 | Per-channel output inversion |
| ch_ie | input | 4 | Per-channel interrupt enable |
| cmp_wr | input | 4 | Per-channel compare write strobe |
| cmp_wdata | input | 16 | Compare value to write |
| flag_clr | input | 4 | Per-channel flag clear strobe |
| pwm_out | output | 4 | PWM outputs |
| cmp_flag | output | 4 | Sticky compare flags |
| irq | output | 1 | Shared interrupt request |

## Verification
The assertions assume that all inputs are synchronous to `clk`, and that `tmr_reload` is a single-cycle pulse sent while the timer holds its reload value. In centre-aligned mode they also assume that `tmr_dir_down` reflects the direction of the count presented in the same cycle. The stimulus changes every input only at the falling edge and raises the reload strobe only with the timer at 0. It uses compare values that each match once per pass, so the timer sequence the assertions rely on always stays well formed.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int unsigned CPWM_NCH = 4;
  localparam int unsigned CPWM_TW  = 16;
endpackage

// File: rtl/cpwm_shadow.sv
module cpwm_shadow #(
  parameter int unsigned TW = cpwm_pkg::CPWM_TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [TW-1:0] wdata,
  input  logic          reload,
  output logic [TW-1:0] act_val
);
  logic [TW-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= '0;
      act_val <= '0;
    end else begin
      if (wr)     held_q  <= wdata;
      if (reload) act_val <= held_q;
    end
  end

  // R8: active value moves only at reload
  p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(act_val));
  // R8: at reload the previously held value is taken
  p_act_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (act_val == $past(held_q)));
endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel #(
  parameter int unsigned TW = cpwm_pkg::CPWM_TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sym,
  input  logic          dir_down,
  input  logic          reload,
  input  logic [TW-1:0] tmr,
  input  logic [TW-1:0] cmp,
  input  logic          pol,
  input  logic          clr,
  output logic          out,
  output logic          flag
);
  logic lvl_q;
  logic hit;

  assign hit = en && (tmr == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (!en) begin
        lvl_q <= 1'b0;
      end else if (sym) begin
        if (hit) lvl_q <= !dir_down;
      end else begin
        if (hit)         lvl_q <= 1'b0;
        else if (reload) lvl_q <= 1'b1;
      end
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  assign out = lvl_q ^ pol;

  // R2: a disabled channel is inactive after the edge
  p_dis_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !lvl_q);
  // R2: a disabled channel never raises its flag
  p_dis_noflag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !flag) |=> !flag);
  // R3: a match sets the flag even against a clear
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tmr == cmp) |=> flag);
  // R6: edge-aligned reload without match goes active
  p_asym_rld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sym && reload && tmr != cmp) |=> lvl_q);
  // R7: centre-aligned up-count match goes active
  p_sym_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sym && tmr == cmp && !dir_down) |=> lvl_q);
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top #(
  parameter int unsigned NCH = cpwm_pkg::CPWM_NCH,
  parameter int unsigned TW  = cpwm_pkg::CPWM_TW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  tmr_val,
  input  logic           tmr_dir_down,
  input  logic           tmr_reload,
  input  logic           sym_mode,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ch_pol,
  input  logic [NCH-1:0] ch_ie,
  input  logic [NCH-1:0] cmp_wr,
  input  logic [TW-1:0]  cmp_wdata,
  input  logic [NCH-1:0] flag_clr,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] cmp_flag,
  output logic           irq
);
  logic [TW-1:0] act_cmp [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cpwm_shadow #(.TW(TW)) u_shd (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cmp_wr[g]),
      .wdata   (cmp_wdata),
      .reload  (tmr_reload),
      .act_val (act_cmp[g])
    );
    cpwm_channel #(.TW(TW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ch_en[g]),
      .sym      (sym_mode),
      .dir_down (tmr_dir_down),
      .reload   (tmr_reload),
      .tmr      (tmr_val),
      .cmp      (act_cmp[g]),
      .pol      (ch_pol[g]),
      .clr      (flag_clr[g]),
      .out      (pwm_out[g]),
      .flag     (cmp_flag[g])
    );
  end

  assign irq = |(cmp_flag & ch_ie);

  // R4: a fresh request needs an enabled, set flag
  p_irq_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((cmp_flag & ch_ie) != '0));
endmodule

// File: tb/test_cpwm_top.sv
`timescale 1ns/1ps
module test_cpwm_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] tmr_val;
  logic        tmr_dir_down, tmr_reload, sym_mode;
  logic [3:0]  ch_en, ch_pol, ch_ie, cmp_wr, flag_clr;
  logic [15:0] cmp_wdata;
  logic [3:0]  pwm_out, cmp_flag;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpwm_top i_cpwm_top (
    .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .tmr_dir_down(tmr_dir_down),
    .tmr_reload(tmr_reload), .sym_mode(sym_mode), .ch_en(ch_en), .ch_pol(ch_pol),
    .ch_ie(ch_ie), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .flag_clr(flag_clr),
    .pwm_out(pwm_out), .cmp_flag(cmp_flag), .irq(irq)
  );

  // {timer, reload, clear, expected out, expected flags}; pol=0100, asym
  localparam logic [28:0] VEC [0:8] = '{
    {16'd0,   1'b1, 4'b0000, 4'b0100, 4'b1111},
    {16'd1,   1'b0, 4'b1111, 4'b0100, 4'b0000},
    {16'd0,   1'b1, 4'b0000, 4'b1011, 4'b0000},
    {16'd1,   1'b0, 4'b0000, 4'b1011, 4'b0000},
    {16'd3,   1'b0, 4'b0000, 4'b1010, 4'b0001},
    {16'd5,   1'b0, 4'b0000, 4'b1100, 4'b0111},
    {16'd6,   1'b0, 4'b0001, 4'b1100, 4'b0110},
    {16'd100, 1'b0, 4'b0000, 4'b0100, 4'b1110},
    {16'd0,   1'b1, 4'b1111, 4'b1011, 4'b0000}
  };

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic step(input logic [15:0] tv, input logic dn, input logic rld,
                      input logic [3:0] clr);
    tmr_val = tv; tmr_dir_down = dn; tmr_reload = rld; flag_clr = clr;
    @(posedge clk);
    @(negedge clk);
    tmr_reload = 1'b0; flag_clr = '0; cmp_wr = '0;
  endtask

  task automatic wr_cmp(input int ch, input logic [15:0] v);
    cmp_wr = 4'b0001 << ch; cmp_wdata = v;
    step(16'd50, 1'b0, 1'b0, 4'b0000);
  endtask

  initial begin
    rst_n = 1'b0; tmr_val = 16'd50; tmr_dir_down = 0; tmr_reload = 0;
    sym_mode = 0; ch_en = '0; ch_pol = 4'b0100; ch_ie = 4'b0011;
    cmp_wr = '0; cmp_wdata = '0; flag_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset out", pwm_out, 4'b0100);
    chk("R9 reset flags", cmp_flag, 4'b0000);
    chk("R9 reset irq", {3'b0, irq}, 4'b0000);

    wr_cmp(0, 16'd3); wr_cmp(1, 16'd5); wr_cmp(2, 16'd5); wr_cmp(3, 16'd100);
    ch_en = 4'b1111;
    // R1 R3 R4 R5 R6 R8: edge-aligned pass
    for (int k = 0; k < 9; k++) begin
      step(VEC[k][28:13], 1'b0, VEC[k][12], VEC[k][11:8]);
      chk($sformatf("R6 R5 row%0d out", k), pwm_out, VEC[k][7:4]);
      chk($sformatf("R3 R1 row%0d flag", k), cmp_flag, VEC[k][3:0]);
      chk($sformatf("R4 row%0d irq", k), {3'b0, irq}, {3'b0, |(VEC[k][3:0] & 4'b0011)});
    end

    // R3: match beats clear
    step(16'd3, 1'b0, 1'b0, 4'b0001);
    chk("R3 set beats clear", {3'b0, cmp_flag[0]}, 4'd1);

    // R8: held value waits for reload
    cmp_wr = 4'b0001; cmp_wdata = 16'd9;
    step(16'd50, 1'b0, 1'b0, 4'b1111);
    step(16'd9, 1'b0, 1'b0, 4'b0000);
    chk("R8 no match before reload", {3'b0, cmp_flag[0]}, 4'd0);
    step(16'd0, 1'b0, 1'b1, 4'b0000);
    step(16'd9, 1'b0, 1'b0, 4'b0000);
    chk("R8 match after reload", {3'b0, cmp_flag[0]}, 4'd1);

    // R2: disabled channel idles at inactive level
    ch_pol = 4'b0101; ch_en = 4'b1110;
    step(16'd0, 1'b0, 1'b1, 4'b1111);
    chk("R2 disabled out", pwm_out, 4'b1011);
    step(16'd9, 1'b0, 1'b0, 4'b0000);
    chk("R2 disabled flag", cmp_flag, 4'b0000);

    // R5: polarity applies at once
    ch_pol = 4'b0000; #1;
    chk("R5 pol clear", pwm_out, 4'b1110);
    ch_pol = 4'b1111; #1;
    chk("R5 pol set", pwm_out, 4'b0001);
    ch_pol = 4'b0000;

    // R7: centre-aligned
    sym_mode = 1'b1; ch_en = 4'b1111;
    step(16'd5, 1'b1, 1'b0, 4'b1111);
    step(16'd100, 1'b1, 1'b0, 4'b0000);
    chk("R7 down matches idle", pwm_out, 4'b0000);
    step(16'd0, 1'b0, 1'b1, 4'b0000);
    chk("R7 reload no effect", pwm_out, 4'b0000);
    step(16'd5, 1'b0, 1'b0, 4'b0000);
    chk("R7 up B C", pwm_out, 4'b0110);
    step(16'd9, 1'b0, 1'b0, 4'b0000);
    chk("R7 up A", pwm_out, 4'b0111);
    step(16'd9, 1'b1, 1'b0, 4'b0000);
    chk("R7 down A", pwm_out, 4'b0110);
    step(16'd5, 1'b1, 1'b0, 4'b0000);
    chk("R7 down B C", pwm_out, 4'b0000);

    // R6: match and reload together -> inactive
    sym_mode = 1'b0;
    wr_cmp(0, 16'd0);
    step(16'd0, 1'b0, 1'b1, 4'b0000);
    chk("R6 reload active", pwm_out, 4'b1111);
    step(16'd0, 1'b0, 1'b1, 4'b0000);
    chk("R6 match wins", pwm_out, 4'b1110);

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule